// File: doc/BRIEF.md
# Byte Lane Permutation Operand Stage

This block sits in the register-read stage in front of a SIMD adder. It takes two 64-bit vector operands, each made of eight byte lanes, and reorders the lanes of the first operand by an organization pattern carried in the instruction. The pattern holds eight 3-bit lane selectors. Because the shuffle is folded into the arithmetic operation, operands need no separate reorganizing instruction and no extra issue slot.

A 2-bit opcode picks one of four actions:
- pass the first operand through unchanged;
- add the permuted first operand lane-wise to the second;
- broadcast one source lane of the first operand to every lane and add the second;
- merge lanes from both operands under a per-lane source mask.

The result is registered and comes out one clock after a valid input, with its own valid strobe. Instruction decode and the register file are outside the block, so it receives decoded fields.

Top module: `lane_org_stage`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0 and `result` is all zeros.
- R2: A cycle with `in_valid` high produces `out_valid` high and the matching `result` on the next rising clock edge. A cycle with `in_valid` low produces `out_valid` low on the next edge.
- R3: `result` keeps its value across any cycle in which `in_valid` is low, whatever the other inputs do.
- R4: Byte lane k of any vector occupies bits [8k+7:8k]. The selector for output lane i occupies `pattern` bits [3i+2:3i]. A pattern written as a colon list, for example 3:4:7:0:1:2:6:5, places its first entry in lane 7 (bits 23:21) and its last entry in lane 0 (bits 2:0).
- R5: Opcode 2'b00 (pass) gives `result` = `opnd_a`. `pattern`, `opnd_b` and `src_hi` have no effect.
- R6: Opcode 2'b01 (permuted add) gives result lane i = `opnd_a` lane sel_i + `opnd_b` lane i.
- R7: Every lane addition wraps modulo 256, and no carry passes into the neighbouring lane.
- R8: Opcode 2'b10 (broadcast) gives result lane i = `opnd_a` lane sel_0 + `opnd_b` lane i, where sel_0 is `pattern` bits [2:0]. The other selectors have no effect.
- R9: Opcode 2'b11 (merge) gives result lane i = `opnd_b` lane sel_i when `src_hi` bit i is 1, and `opnd_a` lane sel_i when it is 0. No addition takes place.
- R10: `src_hi` has no effect for opcodes 2'b00, 2'b01 and 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded fields are valid this cycle |
| op | input | 2 | Action: 00 pass, 01 permuted add, 10 broadcast, 11 merge |
| pattern | input | 24 | Eight 3-bit lane selectors, lane i at bits [3i+2:3i] |
| src_hi | input | 8 | Per-lane merge mask; bit i set takes lane i from the second operand |
| opnd_a | input | 64 | First vector operand, the one that is permuted |
| opnd_b | input | 64 | Second vector operand |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Registered lane-wise result |

## Verification
Every result is due exactly one rising edge after the cycle in which `in_valid` is sampled high. The bench drives inputs at the falling edge, lets one rising edge capture them, and compares `result` and `out_valid` at the following falling edge, so each comparison sits half a period clear of the capture edge.

Hold and ignored-input checks change the inputs with `in_valid` low. They then look at the outputs one falling edge later, which is after the rising edge that could have disturbed them.

// File: rtl/lane_org_pkg.sv
package lane_org_pkg;

    localparam int LANES  = 8;
    localparam int LANE_W = 8;
    localparam int SEL_W  = $clog2(LANES);
    localparam int VEC_W  = LANES * LANE_W;
    localparam int PAT_W  = LANES * SEL_W;

    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [PAT_W-1:0]  pat_t;
    typedef logic [LANES-1:0]  mask_t;

    typedef enum logic [1:0] {
        OP_PASS  = 2'd0,
        OP_PADD  = 2'd1,
        OP_BCAST = 2'd2,
        OP_MERGE = 2'd3
    } org_op_e;

    typedef struct packed {
        logic valid;
        vec_t data;
    } stage_t;

    // Replicate the lane-0 selector into every lane slot.
    function automatic pat_t bcast_pattern(input pat_t p);
        pat_t r;
        for (int i = 0; i < LANES; i++) begin
            r[i*SEL_W +: SEL_W] = p[SEL_W-1:0];
        end
        return r;
    endfunction

    // True when every byte lane of v equals lane 0.
    function automatic logic lanes_equal(input vec_t v);
        logic eq;
        eq = 1'b1;
        for (int i = 1; i < LANES; i++) begin
            if (v[i*LANE_W +: LANE_W] != v[LANE_W-1:0]) eq = 1'b0;
        end
        return eq;
    endfunction

endpackage

// File: rtl/lane_crossbar.sv
module lane_crossbar
    import lane_org_pkg::*;
(
    input  vec_t src,
    input  pat_t sel,
    output vec_t dst
);
    // One selector-driven mux per output lane (R4).
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SEL_W-1:0]  s;
        logic [LANE_W-1:0] pick;
        assign s = sel[i*SEL_W +: SEL_W];
        always_comb begin
            pick = '0;
            for (int k = 0; k < LANES; k++) begin
                if (s == SEL_W'(k)) pick = src[k*LANE_W +: LANE_W];
            end
        end
        assign dst[i*LANE_W +: LANE_W] = pick;
    end
endmodule

// File: rtl/lane_adder.sv
module lane_adder
    import lane_org_pkg::*;
(
    input  vec_t x,
    input  vec_t y,
    output vec_t sum
);
    // Independent per-lane adders; the carry out of each lane is dropped (R7).
    for (genvar i = 0; i < LANES; i++) begin : g_add
        assign sum[i*LANE_W +: LANE_W] = x[i*LANE_W +: LANE_W] + y[i*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/lane_merge.sv
module lane_merge
    import lane_org_pkg::*;
(
    input  vec_t  from_a,
    input  vec_t  from_b,
    input  mask_t take_b,
    output vec_t  mixed
);
    // Per-lane choice between the two permuted operands (R9).
    for (genvar i = 0; i < LANES; i++) begin : g_mix
        assign mixed[i*LANE_W +: LANE_W] = take_b[i] ? from_b[i*LANE_W +: LANE_W]
                                                      : from_a[i*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/lane_org_stage.sv
module lane_org_stage
    import lane_org_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [1:0]                   op,
    input  logic [lane_org_pkg::PAT_W-1:0] pattern,
    input  logic [lane_org_pkg::LANES-1:0] src_hi,
    input  logic [lane_org_pkg::VEC_W-1:0] opnd_a,
    input  logic [lane_org_pkg::VEC_W-1:0] opnd_b,
    output logic                         out_valid,
    output logic [lane_org_pkg::VEC_W-1:0] result
);
    org_op_e op_e;
    pat_t    a_sel;
    vec_t    a_perm, b_perm, sum_v, mix_v;
    vec_t    next_data;
    stage_t  st_q;

    assign op_e  = org_op_e'(op);
    assign a_sel = (op_e == OP_BCAST) ? bcast_pattern(pattern) : pattern;

    lane_crossbar u_xbar_a (.src(opnd_a), .sel(a_sel),   .dst(a_perm));
    lane_crossbar u_xbar_b (.src(opnd_b), .sel(pattern), .dst(b_perm));
    lane_adder    u_add    (.x(a_perm), .y(opnd_b), .sum(sum_v));
    lane_merge    u_mix    (.from_a(a_perm), .from_b(b_perm), .take_b(src_hi), .mixed(mix_v));

    always_comb begin
        unique case (op_e)
            OP_PASS:  next_data = opnd_a;
            OP_PADD,
            OP_BCAST: next_data = sum_v;
            default:  next_data = mix_v;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q.valid <= in_valid;
            if (in_valid) st_q.data <= next_data;
        end
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.data;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R3
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));
    // R5
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b00) |=> (result == $past(opnd_a)));
    // R8
    bcast_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b10 && opnd_b == '0) |=> lanes_equal(result));

endmodule

// File: tb/sim_lane_org_stage.sv
module sim_lane_org_stage;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  op;
    logic [23:0] pattern;
    logic [7:0]  src_hi;
    logic [63:0] opnd_a, opnd_b;
    logic        out_valid;
    logic [63:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    lane_org_stage u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .pattern(pattern),
        .src_hi(src_hi), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] model(input logic [1:0] o, input logic [23:0] p,
                                          input logic [7:0] m, input logic [63:0] a,
                                          input logic [63:0] b);
        logic [63:0] r;
        if (o == 2'd0) return a;
        for (int i = 0; i < 8; i++) begin
            int s;
            s = (o == 2'd2) ? int'(p[2:0]) : int'((p >> (3*i)) & 24'd7);
            if (o == 2'd3)
                r[8*i +: 8] = m[i] ? b[8*s +: 8] : a[8*s +: 8];
            else
                r[8*i +: 8] = 8'((int'(a[8*s +: 8]) + int'(b[8*i +: 8])) % 256);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one valid input, then check at the falling edge after capture.
    task automatic issue(input string req, input logic [1:0] o, input logic [23:0] p,
                         input logic [7:0] m, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; op = o; pattern = p; src_hi = m; opnd_a = a; opnd_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
        check(req, result, model(o, p, m, a, b));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        rst = 1'b1; in_valid = 1'b0; op = 2'd0; pattern = '0; src_hi = '0;
        opnd_a = 64'h0706050403020100; opnd_b = 64'h1111111111111111;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 valid", {63'd0, out_valid}, 64'd0);
        check("R1 result", result, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 first cycle", result, 64'd0);

        // R4 written list 3:4:7:0:1:2:6:5 -> lane7=3 ... lane0=5
        issue("R4 R6 list order", 2'd1, {3'd3,3'd4,3'd7,3'd0,3'd1,3'd2,3'd6,3'd5}, 8'h00,
              64'h0706050403020100, 64'h0);
        check("R4 explicit", result, 64'h0304070001020605);
        // R7 wrap without carry
        issue("R7 wrap", 2'd1, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 8'h00,
              64'hFFFFFFFFFFFFFFFF, 64'h0101010101010101);
        check("R7 explicit", result, 64'h0);
        // R8 broadcast of lane 6, other selectors scrambled
        issue("R8 bcast", 2'd2, {3'd1,3'd2,3'd3,3'd4,3'd5,3'd0,3'd7,3'd6}, 8'hFF,
              64'hA0B1C2D3E4F50617, 64'h0);
        check("R8 explicit", result, 64'hB1B1B1B1B1B1B1B1);
        // R9 merge
        issue("R9 merge", 2'd3, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 8'hF0,
              64'h1111111111111111, 64'h2222222222222222);
        check("R9 explicit", result, 64'h2222222211111111);

        // R3 hold while inputs change with valid low; R2 valid drop
        held = result;
        @(negedge clk);
        opnd_a = ~opnd_a; opnd_b = ~opnd_b; op = 2'd0; pattern = ~pattern;
        @(negedge clk);
        check("R3 hold", result, held);
        check("R2 valid drop", {63'd0, out_valid}, 64'd0);

        // Sweep: each opcode, every selector value in every lane, varied data.
        for (int o = 0; o < 4; o++) begin
            for (int lane = 0; lane < 8; lane++) begin
                for (int v = 0; v < 8; v++) begin
                    logic [23:0] p;
                    logic [63:0] a, b;
                    logic [7:0]  m;
                    p = 24'({$urandom} & 32'hFFFFFF);
                    p[3*lane +: 3] = 3'(v);
                    a = {$urandom, $urandom};
                    b = {$urandom, $urandom};
                    m = 8'($urandom);
                    // R5 R6 R8 R9 R10 against the arithmetic model
                    case (o)
                        0: issue("R5 R10 pass sweep", 2'(o), p, m, a, b);
                        1: issue("R6 R10 add sweep", 2'(o), p, m, a, b);
                        2: issue("R8 R10 bcast sweep", 2'(o), p, m, a, b);
                        default: issue("R9 merge sweep", 2'(o), p, m, a, b);
                    endcase
                end
            end
        end

        // R10 mask has no effect: same add with two masks
        issue("R10 mask 00", 2'd1, 24'h53977A, 8'h00, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210);
        held = result;
        issue("R10 mask FF", 2'd1, 24'h53977A, 8'hFF, 64'h0123456789ABCDEF, 64'hFEDCBA9876543210);
        check("R10 equal", result, held);

        // R1 reset clears a live result
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reclear", result, 64'd0);
        rst = 1'b0;

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule